// File: doc/BRIEF.md
# Exception-Aware Control Register Unit

This block keeps a processor's status and control state in one place. It holds a status word that carries the current stack-select, interrupt-enable and condition bits, together with a saved copy of each of them. It also holds a read-only mirror of the condition bit, an interrupt-side stack pointer, a user-side stack pointer and a saved program counter. The execute stage reaches these values through a control-register space. It also reaches them through the general-register space, where index 15 is routed to whichever stack pointer the stack-select bit picks.

Two strobes come from the exception logic. The entry strobe moves the current status bits into the saved fields, switches to the interrupt stack with interrupts disabled, and captures the program counter of the interrupted code. The return strobe copies the saved fields back into the current ones. The unit also outputs the resume address, which is always aligned to a 32-bit word, and the masking result for the two interrupt sources. The maskable external interrupt depends on the enable bit. The system break interrupt does not.

Top module: `crs_unit`

## Requirements
- R1: After reset every stored field is zero: all status bits, both stack pointers and the saved PC. The outputs `stk_sel`, `int_en`, `cond` and `ret_pc` are zero.
- R2: Control index 0 is the status word. Bit 0 is the current condition, bit 6 the current interrupt enable, bit 7 the current stack select, bit 8 the saved condition, bit 14 the saved enable and bit 15 the saved stack select. Writes update exactly these six bits. All other bits read as 0.
- R3: Control index 1 reads the current condition in bit 0 and zero elsewhere. A write to index 1 has no effect on any state.
- R4: General index 15 reads and writes the interrupt stack pointer when the stack select is 1, and the user stack pointer when it is 0. Control index 2 always reaches the interrupt stack pointer and control index 3 always reaches the user stack pointer.
- R5: Control index 6 is the saved PC. A write stores the data with bit 0 cleared.
- R6: On `evt_enter`, the saved status bits take the values of the current ones, the stack select becomes 1 and the enable becomes 0. The condition is kept, and the saved PC takes `evt_pc` with bit 0 cleared.
- R7: On `evt_return` the current status bits take the saved values and the saved bits are unchanged. `ret_pc` always equals the saved PC with bits 1:0 cleared.
- R8: When strobes and writes coincide in one cycle, `evt_enter` wins over `evt_return`, and either strobe discards a register write made in that cycle.
- R9: `ext_take` is `ext_irq` gated by the interrupt enable. `sbi_take` follows `sbi_req` whatever the enable.
- R10: Control indices 4, 5 and 7 to 15, and general indices other than 15, read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_ctl | input | 1 | 1 selects control-register space, 0 general-register space |
| reg_idx | input | 4 | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for the selected index |
| evt_enter | input | 1 | Exception/interrupt/trap entry strobe |
| evt_pc | input | DW | PC value to save on entry |
| evt_return | input | 1 | Return-from-event strobe |
| ext_irq | input | 1 | Maskable external interrupt request |
| sbi_req | input | 1 | System break interrupt request |
| ext_take | output | 1 | External request accepted |
| sbi_take | output | 1 | System break request accepted |
| stk_sel | output | 1 | Current stack select (1 = interrupt stack) |
| int_en | output | 1 | Current interrupt enable |
| cond | output | 1 | Current condition bit |
| ret_pc | output | DW | Word-aligned resume address |

## Verification
Any wrong status bit shows up combinationally on `stk_sel`, `int_en`, `cond` or `ext_take` in the cycle after the faulty update. The saved fields show up through a status-word read right away, and through the current outputs one cycle after a return strobe. A broken stack bank shows when index 15 is read and the value differs from the one last written through control index 2 or 3. A corrupted saved PC appears on `ret_pc` without delay. The tests therefore read every field back directly after each entry, return, collision or ignored write.

// File: rtl/crs_unit.sv
module crs_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_ctl,
  input  logic [3:0]    reg_idx,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          evt_enter,
  input  logic [DW-1:0] evt_pc,
  input  logic          evt_return,
  input  logic          ext_irq,
  input  logic          sbi_req,
  output logic          ext_take,
  output logic          sbi_take,
  output logic          stk_sel,
  output logic          int_en,
  output logic          cond,
  output logic [DW-1:0] ret_pc
);
  localparam logic [3:0] CI_STAT = 4'd0;
  localparam logic [3:0] CI_CMIR = 4'd1;
  localparam logic [3:0] CI_ISP  = 4'd2;
  localparam logic [3:0] CI_USP  = 4'd3;
  localparam logic [3:0] CI_SPC  = 4'd6;
  localparam logic [3:0] GI_SP   = 4'd15;

  localparam int B_C  = 0;
  localparam int B_IE = 6;
  localparam int B_SM = 7;
  localparam int B_BC = 8;
  localparam int B_BI = 14;
  localparam int B_BS = 15;

  logic          sm_q, ie_q, c_q, bsm_q, bie_q, bc_q;
  logic [DW-1:0] isp_q, usp_q, spc_q;
  logic [DW-1:0] stat_word;

  wire strobe  = evt_enter | evt_return;
  wire ctl_wr  = wr_en & is_ctl & ~strobe;
  wire gsp_wr  = wr_en & ~is_ctl & (reg_idx == GI_SP) & ~strobe;
  wire isp_wr  = (ctl_wr & (reg_idx == CI_ISP)) | (gsp_wr & sm_q);
  wire usp_wr  = (ctl_wr & (reg_idx == CI_USP)) | (gsp_wr & ~sm_q);

  always_comb begin
    stat_word       = '0;
    stat_word[B_C]  = c_q;
    stat_word[B_IE] = ie_q;
    stat_word[B_SM] = sm_q;
    stat_word[B_BC] = bc_q;
    stat_word[B_BI] = bie_q;
    stat_word[B_BS] = bsm_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sm_q  <= 1'b0;
      ie_q  <= 1'b0;
      c_q   <= 1'b0;
      bsm_q <= 1'b0;
      bie_q <= 1'b0;
      bc_q  <= 1'b0;
      spc_q <= '0;
    end else if (evt_enter) begin
      bsm_q <= sm_q;
      bie_q <= ie_q;
      bc_q  <= c_q;
      sm_q  <= 1'b1;
      ie_q  <= 1'b0;
      spc_q <= {evt_pc[DW-1:1], 1'b0};
    end else if (evt_return) begin
      sm_q <= bsm_q;
      ie_q <= bie_q;
      c_q  <= bc_q;
    end else if (ctl_wr) begin
      if (reg_idx == CI_STAT) begin
        c_q   <= wr_data[B_C];
        ie_q  <= wr_data[B_IE];
        sm_q  <= wr_data[B_SM];
        bc_q  <= wr_data[B_BC];
        bie_q <= wr_data[B_BI];
        bsm_q <= wr_data[B_BS];
      end
      if (reg_idx == CI_SPC) spc_q <= {wr_data[DW-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isp_q <= '0;
      usp_q <= '0;
    end else begin
      if (isp_wr) isp_q <= wr_data;
      if (usp_wr) usp_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (is_ctl) begin
      case (reg_idx)
        CI_STAT: rd_data = stat_word;
        CI_CMIR: rd_data = {{(DW-1){1'b0}}, c_q};
        CI_ISP:  rd_data = isp_q;
        CI_USP:  rd_data = usp_q;
        CI_SPC:  rd_data = spc_q;
        default: rd_data = '0;
      endcase
    end else if (reg_idx == GI_SP) begin
      rd_data = sm_q ? isp_q : usp_q;
    end
  end

  assign ret_pc   = {spc_q[DW-1:2], 2'b00};
  assign stk_sel  = sm_q;
  assign int_en   = ie_q;
  assign cond     = c_q;
  assign ext_take = ext_irq & ie_q;
  assign sbi_take = sbi_req;
endmodule

// File: rtl/crs_unit_chk.sv
module crs_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          is_ctl,
  input logic [3:0]    reg_idx,
  input logic          wr_en,
  input logic [DW-1:0] rd_data,
  input logic          evt_enter,
  input logic [DW-1:0] evt_pc,
  input logic          evt_return,
  input logic          ext_irq,
  input logic          sbi_req,
  input logic          ext_take,
  input logic          sbi_take,
  input logic          sm_q,
  input logic          ie_q,
  input logic          c_q,
  input logic          bsm_q,
  input logic          bie_q,
  input logic          bc_q,
  input logic [DW-1:0] spc_q
);
  a_r6_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter |=> sm_q && !ie_q && c_q == $past(c_q) && bsm_q == $past(sm_q)
                  && bie_q == $past(ie_q) && bc_q == $past(c_q));

  a_r6_entry_pc: assert property (@(posedge clk) disable iff (!rst_n)
    evt_enter |=> spc_q == {$past(evt_pc[DW-1:1]), 1'b0});

  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_return && !evt_enter) |=> sm_q == $past(bsm_q) && ie_q == $past(bie_q)
                  && c_q == $past(bc_q) && bsm_q == $past(bsm_q));

  a_r3_mirror_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_ctl && reg_idx == 4'd1 && !evt_enter && !evt_return)
      |=> $stable(c_q) && $stable(ie_q) && $stable(sm_q) && $stable(spc_q));

  a_r3_mirror_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ctl && reg_idx == 4'd1) |-> rd_data == {{(DW-1){1'b0}}, c_q});

  a_r9_ext_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ext_take |-> (ie_q && ext_irq));

  a_r9_sbi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    sbi_req |-> sbi_take);
endmodule

bind crs_unit crs_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_ctl(is_ctl), .reg_idx(reg_idx), .wr_en(wr_en),
  .rd_data(rd_data), .evt_enter(evt_enter), .evt_pc(evt_pc),
  .evt_return(evt_return), .ext_irq(ext_irq), .sbi_req(sbi_req),
  .ext_take(ext_take), .sbi_take(sbi_take), .sm_q(sm_q), .ie_q(ie_q),
  .c_q(c_q), .bsm_q(bsm_q), .bie_q(bie_q), .bc_q(bc_q), .spc_q(spc_q)
);

// File: tb/tb_crs_unit.sv
module tb_crs_unit;
  localparam int DW = 32;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          is_ctl, wr_en, evt_enter, evt_return, ext_irq, sbi_req;
  logic [3:0]    reg_idx;
  logic [DW-1:0] wr_data, evt_pc, rd_data, ret_pc;
  logic          ext_take, sbi_take, stk_sel, int_en, cond;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  crs_unit #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .is_ctl(is_ctl), .reg_idx(reg_idx),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .evt_enter(evt_enter), .evt_pc(evt_pc), .evt_return(evt_return),
    .ext_irq(ext_irq), .sbi_req(sbi_req), .ext_take(ext_take),
    .sbi_take(sbi_take), .stk_sel(stk_sel), .int_en(int_en), .cond(cond),
    .ret_pc(ret_pc)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    is_ctl = 0; reg_idx = 0; wr_en = 0; wr_data = 0;
    evt_enter = 0; evt_pc = 0; evt_return = 0; ext_irq = 0; sbi_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic ctl, input logic [3:0] idx, input logic [DW-1:0] d);
    is_ctl = ctl; reg_idx = idx; wr_data = d; wr_en = 1;
    step();
    wr_en = 0;
  endtask

  task automatic rd(input logic ctl, input logic [3:0] idx, output logic [DW-1:0] d);
    is_ctl = ctl; reg_idx = idx;
    #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd(1, 0, v); check("R1 status", v, 0);
    rd(1, 2, v); check("R1 isp", v, 0);
    rd(1, 3, v); check("R1 usp", v, 0);
    rd(1, 6, v); check("R1 spc", v, 0);
    check("R1 outs", {stk_sel, int_en, cond}, 0);
    check("R1 ret_pc", ret_pc, 0);
  endtask

  task automatic t_status();
    logic [DW-1:0] v;
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, v); check("R2 all ones", v, 32'h0000_C1C1);
    check("R2 outs", {stk_sel, int_en, cond}, 3'b111);
    wr(1, 0, 32'h0000_4041);
    rd(1, 0, v); check("R2 pattern", v, 32'h0000_4041);
    check("R2 outs2", {stk_sel, int_en, cond}, 3'b011);
  endtask

  task automatic t_mirror();
    logic [DW-1:0] v;
    wr(1, 0, 32'h1);
    rd(1, 1, v); check("R3 mirror one", v, 1);
    wr(1, 1, 32'h0);
    rd(1, 1, v); check("R3 write ignored", v, 1);
    rd(1, 0, v); check("R3 status kept", v, 1);
    wr(1, 0, 32'h0);
    wr(1, 1, 32'hFFFF_FFFF);
    rd(1, 0, v); check("R3 ones ignored", v, 0);
    rd(1, 1, v); check("R3 mirror zero", v, 0);
  endtask

  task automatic t_bank();
    logic [DW-1:0] v;
    wr(1, 0, 32'h0);
    wr(0, 15, 32'h0000_1000);
    rd(1, 3, v); check("R4 usp via gpr", v, 32'h1000);
    rd(1, 2, v); check("R4 isp untouched", v, 0);
    wr(1, 0, 32'h80);
    wr(0, 15, 32'h0000_2000);
    rd(0, 15, v); check("R4 gpr isp", v, 32'h2000);
    rd(1, 2, v); check("R4 isp via gpr", v, 32'h2000);
    rd(1, 3, v); check("R4 usp kept", v, 32'h1000);
    wr(1, 2, 32'h0000_3000);
    rd(0, 15, v); check("R4 ctl isp seen", v, 32'h3000);
    wr(1, 0, 32'h0);
    rd(0, 15, v); check("R4 back to usp", v, 32'h1000);
  endtask

  task automatic t_spc();
    logic [DW-1:0] v;
    wr(1, 6, 32'h1234_5677);
    rd(1, 6, v); check("R5 spc bit0", v, 32'h1234_5676);
    check("R7 ret_pc align", ret_pc, 32'h1234_5674);
  endtask

  task automatic t_entry_return();
    logic [DW-1:0] v;
    wr(1, 0, 32'h41);
    evt_enter = 1; evt_pc = 32'hABCD_0003;
    step();
    evt_enter = 0;
    rd(1, 0, v); check("R6 entry status", v, 32'h0000_4181);
    rd(1, 6, v); check("R6 entry spc", v, 32'hABCD_0002);
    check("R7 ret_pc", ret_pc, 32'hABCD_0000);
    evt_return = 1;
    step();
    evt_return = 0;
    rd(1, 0, v); check("R7 return status", v, 32'h0000_4141);
    check("R7 outs", {stk_sel, int_en, cond}, 3'b011);
  endtask

  task automatic t_priority();
    logic [DW-1:0] v;
    wr(1, 0, 32'h40);
    evt_enter = 1; evt_pc = 32'h100;
    is_ctl = 1; reg_idx = 0; wr_data = 32'h0; wr_en = 1;
    step();
    evt_enter = 0; wr_en = 0;
    rd(1, 0, v); check("R8 entry beats write", v, 32'h0000_4080);
    evt_return = 1;
    is_ctl = 1; reg_idx = 0; wr_data = 32'h0000_C1C1; wr_en = 1;
    step();
    evt_return = 0; wr_en = 0;
    rd(1, 0, v); check("R8 return beats write", v, 32'h0000_4040);
    evt_enter = 1; evt_return = 1; evt_pc = 32'h200;
    step();
    evt_enter = 0; evt_return = 0;
    rd(1, 0, v); check("R8 entry beats return", v, 32'h0000_4080);
    rd(1, 6, v); check("R8 spc", v, 32'h200);
  endtask

  task automatic t_irq();
    wr(1, 0, 32'h40);
    ext_irq = 1; sbi_req = 0; #1;
    check("R9 ext enabled", {ext_take, sbi_take}, 2'b10);
    wr(1, 0, 32'h0);
    #1;
    check("R9 ext masked", {ext_take, sbi_take}, 2'b00);
    sbi_req = 1; #1;
    check("R9 sbi unmasked", {ext_take, sbi_take}, 2'b01);
    ext_irq = 0; sbi_req = 0;
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    wr(1, 0, 32'h0);
    wr(1, 3, 32'h5555);
    wr(1, 5, 32'hDEAD_BEEF);
    rd(1, 5, v); check("R10 ctl5 zero", v, 0);
    wr(1, 4, 32'hFFFF_FFFF);
    rd(1, 4, v); check("R10 ctl4 zero", v, 0);
    wr(0, 3, 32'hFFFF_FFFF);
    rd(0, 3, v); check("R10 gpr3 zero", v, 0);
    rd(1, 0, v); check("R10 status kept", v, 0);
    rd(0, 15, v); check("R10 usp kept", v, 32'h5555);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset();
    t_status();
    t_mirror();
    t_bank();
    t_spc();
    t_entry_return();
    t_priority();
    t_irq();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule